// File: doc/BRIEF.md
# Bus Transaction Watchdog

This block sits beside a bus master and guards against a slave that never answers. It keeps a clock counter that stays cleared while no bus cycle is open, starts over on the clock where the cycle line goes high, and advances once per clock while the cycle stays open. The limit is a build-time parameter. If the count reaches that limit and the slave gives no acknowledge on that clock, the block drives a one-clock bus error that the master uses to abandon the cycle.

On the same clock as the error, the block stores the address of the most recent strobed request in the stuck cycle. That value stays in a register that software can read until a later timeout replaces it. After an error, the block stays silent for the rest of that cycle. A new cycle gives it a fresh window.

Top module: `bus_timeout_guard`

## Requirements
- R1: After reset, `bus_err` is 0 and `fault_addr` is all zeros.
- R2: While `bus_cyc` is low, the internal count is held at zero and `bus_err` stays low, whatever `bus_stb`, `bus_ack` and `bus_addr` do.
- R3: A low-to-high change of `bus_cyc` restarts the count, so a cycle dropped for even one clock and raised again gets a full new window.
- R4: Number the clock edges at which `bus_cyc` is sampled high 0, 1, 2 and so on, starting from the edge of its rise. If `bus_cyc` is still high and `bus_ack` is low at edge LIMIT, then `bus_err` is 1 during the clock after that edge. A cycle that is high for LIMIT edges or fewer never produces an error.
- R5: `bus_err` lasts exactly one clock. No second error is produced until `bus_cyc` falls and rises again.
- R6: An acknowledge at the limit edge wins, and no error is produced on that clock. The count then holds at the limit, so the first later edge that has the cycle open and no acknowledge produces the error.
- R7: `fault_addr` changes only on the clock where `bus_err` rises. At all other times it keeps its value.
- R8: The captured address is the `bus_addr` presented at the last edge with both `bus_cyc` and `bus_stb` high, at or before the timeout edge. Addresses seen without a strobe, or strobed after the timeout, are not captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cyc | input | 1 | Bus cycle open |
| bus_stb | input | 1 | Request strobe; `bus_addr` is valid when it is high |
| bus_ack | input | 1 | Slave acknowledge |
| bus_addr | input | AW | Request address |
| bus_err | output | 1 | One-clock forced bus error on timeout |
| fault_addr | output | AW | Address of the request that timed out |

## Verification
The bench goes after the off-by-one edges around the limit. A cycle that is exactly LIMIT edges long must stay quiet, and one edge longer must fault at edge LIMIT. A design that counts from the wrong origin would fire one clock early or one clock late. Acknowledge-on-the-limit tests catch a design that lets the error win the tie, and also one that forgets to fire on the next unanswered edge. Long hung cycles expose a design that pulses repeatedly. A one-clock gap between cycles, and later strobes or address changes that carry no strobe, catch a counter that fails to restart and a capture path that records the wrong address.

// File: rtl/bus_timeout_guard_pkg.sv
`timescale 1ns/1ps
package bus_timeout_guard_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ARMED = 2'd1,
    PH_SPENT = 2'd2
  } guard_phase_e;

  // Next value of the elapsed-clock count.
  function automatic int unsigned wd_step(input int unsigned cnt,
                                          input logic cyc,
                                          input logic start,
                                          input int unsigned limit);
    if (!cyc)          return 0;
    else if (start)    return 1;
    else if (cnt < limit) return cnt + 1;
    else               return cnt;
  endfunction

  function automatic logic wd_at_limit(input int unsigned cnt,
                                       input int unsigned limit);
    return (cnt == limit);
  endfunction

  // Phase transition of the error arming logic.
  function automatic guard_phase_e wd_phase(input guard_phase_e ph,
                                            input logic cyc,
                                            input logic start,
                                            input logic expire);
    if (!cyc)        return PH_IDLE;
    else if (start)  return PH_ARMED;
    else if (expire) return PH_SPENT;
    else             return ph;
  endfunction

endpackage

// File: rtl/bus_timeout_guard_edge.sv
`timescale 1ns/1ps
module bus_timeout_guard_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc,
  output logic start
);
  logic cyc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cyc_q <= 1'b0;
    else        cyc_q <= cyc;
  end

  assign start = cyc & ~cyc_q;
endmodule

// File: rtl/bus_timeout_guard_timer.sv
`timescale 1ns/1ps
module bus_timeout_guard_timer
  import bus_timeout_guard_pkg::*;
#(
  parameter int unsigned LIMIT = 1024,
  parameter int unsigned CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc,
  input  logic          start,
  output logic [CW-1:0] count,
  output logic          at_limit
);
  localparam int unsigned PADW = 32 - CW;

  logic [CW-1:0] count_q;
  int unsigned   count_wide;
  int unsigned   count_next;

  always_comb begin
    count_wide = {{PADW{1'b0}}, count_q};
    count_next = wd_step(count_wide, cyc, start, LIMIT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_next[CW-1:0];
  end

  assign count    = count_q;
  assign at_limit = wd_at_limit(count_wide, LIMIT);
endmodule

// File: rtl/bus_timeout_guard_capture.sv
`timescale 1ns/1ps
module bus_timeout_guard_capture #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc,
  input  logic          stb,
  input  logic [AW-1:0] addr,
  input  logic          expire,
  output logic [AW-1:0] fault_addr
);
  logic [AW-1:0] req_q;
  logic [AW-1:0] fault_q;
  logic          req_now;
  logic [AW-1:0] live_addr;

  assign req_now   = cyc & stb;
  assign live_addr = req_now ? addr : req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= '0;
      fault_q <= '0;
    end else begin
      if (req_now) req_q   <= addr;
      if (expire)  fault_q <= live_addr;
    end
  end

  assign fault_addr = fault_q;
endmodule

// File: rtl/bus_timeout_guard.sv
`timescale 1ns/1ps
module bus_timeout_guard
  import bus_timeout_guard_pkg::*;
#(
  parameter int unsigned LIMIT = 1024,
  parameter int unsigned AW    = 32,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cyc,
  input  logic          bus_stb,
  input  logic          bus_ack,
  input  logic [AW-1:0] bus_addr,
  output logic          bus_err,
  output logic [AW-1:0] fault_addr
);
  // Named internal events, visible to the bound checker.
  logic          cyc_start;
  logic [CW-1:0] tick_count;
  logic          tick_at_limit;
  logic          expire;
  guard_phase_e  phase_q;
  logic          err_q;

  bus_timeout_guard_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .cyc   (bus_cyc),
    .start (cyc_start)
  );

  bus_timeout_guard_timer #(.LIMIT(LIMIT), .CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc      (bus_cyc),
    .start    (cyc_start),
    .count    (tick_count),
    .at_limit (tick_at_limit)
  );

  assign expire = bus_cyc & tick_at_limit & ~bus_ack & (phase_q == PH_ARMED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      err_q   <= 1'b0;
    end else begin
      phase_q <= wd_phase(phase_q, bus_cyc, cyc_start, expire);
      err_q   <= expire;
    end
  end

  bus_timeout_guard_capture #(.AW(AW)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc        (bus_cyc),
    .stb        (bus_stb),
    .addr       (bus_addr),
    .expire     (expire),
    .fault_addr (fault_addr)
  );

  assign bus_err = err_q;
endmodule

// File: rtl/bus_timeout_guard_chk.sv
`timescale 1ns/1ps
module bus_timeout_guard_chk #(
  parameter int unsigned LIMIT = 1024,
  parameter int unsigned AW    = 32,
  parameter int unsigned CW    = $clog2(LIMIT + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_cyc,
  input logic          bus_ack,
  input logic          bus_err,
  input logic          cyc_start,
  input logic [CW-1:0] tick_count,
  input logic [AW-1:0] fault_addr
);
  // R2: idle cycle clears the count
  a_r2_idle_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cyc |=> (tick_count == '0));

  // R2: no error follows an idle clock
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cyc |=> !bus_err);

  // R3: a rising cycle opens a fresh window
  a_r3_fresh_window: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> (tick_count == CW'(1)));

  // R4: an error only follows a limit edge with the cycle open
  a_r4_fires_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> ($past(tick_count) == CW'(LIMIT)) && $past(bus_cyc));

  // R5: one-clock pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> !bus_err);

  // R6: acknowledge wins the tie
  a_r6_ack_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_ack) |=> !bus_err);

  // R7: the captured address moves only with an error
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_err |-> $stable(fault_addr));
endmodule

bind bus_timeout_guard bus_timeout_guard_chk #(
  .LIMIT (LIMIT),
  .AW    (AW),
  .CW    (CW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_cyc    (bus_cyc),
  .bus_ack    (bus_ack),
  .bus_err    (bus_err),
  .cyc_start  (cyc_start),
  .tick_count (tick_count),
  .fault_addr (fault_addr)
);

// File: tb/sim_bus_timeout_guard.sv
`timescale 1ns/1ps
module sim_bus_timeout_guard;
  localparam int unsigned LIMIT = 6;
  localparam int unsigned AW    = 16;
  localparam int          NVEC  = 10;

  // Fields: [31:24] edges held high, [23:16] ack edge (FF none),
  //         [15:8] second strobe edge (FF none), [7:0] address tag
  localparam logic [31:0] VEC [0:NVEC-1] = '{
    32'h03_02_FF_11,   // short, acked: quiet
    32'h06_FF_FF_22,   // exactly LIMIT edges: quiet (R4 boundary)
    32'h07_FF_FF_33,   // one past: fault at edge LIMIT (R4)
    32'h07_06_FF_44,   // ack on limit edge, then closed (R6)
    32'h08_06_FF_55,   // ack on limit edge, then unanswered (R6)
    32'h0C_FF_FF_66,   // hung long: single pulse (R5)
    32'h07_03_02_77,   // later strobe before timeout (R8)
    32'h06_FF_FF_88,   // fresh window after fault (R3)
    32'h0A_FF_08_99,   // strobe after timeout ignored (R8)
    32'h02_FF_FF_AA    // short, never acked: quiet
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_cyc, bus_stb, bus_ack;
  logic [AW-1:0] bus_addr;
  logic          bus_err;
  logic [AW-1:0] fault_addr;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;
  logic [AW-1:0] exp_fault = '0;

  always #4 clk = ~clk;   // 125 MHz

  bus_timeout_guard #(.LIMIT(LIMIT), .AW(AW)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_cyc    (bus_cyc),
    .bus_stb    (bus_stb),
    .bus_ack    (bus_ack),
    .bus_addr   (bus_addr),
    .bus_err    (bus_err),
    .fault_addr (fault_addr)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Edge of the expected error, -1 when none (R4, R6).
  function automatic int exp_err_edge(input int hold, input int ack_idx);
    if (hold <= int'(LIMIT))  return -1;
    if (ack_idx != int'(LIMIT)) return int'(LIMIT);
    if (hold >= int'(LIMIT) + 2) return int'(LIMIT) + 1;
    return -1;
  endfunction

  task automatic run_txn(input logic [AW-1:0] a0, input int hold, input int ack_idx,
                         input int stb2_idx, input logic [AW-1:0] a2, input string req);
    int first_err = -1;
    int pulses    = 0;
    int want;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      bus_cyc  = 1'b1;
      bus_stb  = (i == 0) || (i == stb2_idx);
      bus_addr = (i == 0) ? a0 : (i == stb2_idx) ? a2 : (16'hC000 | AW'(i));
      bus_ack  = (i == ack_idx);
      @(posedge clk); #1;
      if (bus_err) begin
        pulses++;
        if (first_err < 0) first_err = i;
      end
    end
    @(negedge clk);
    bus_cyc = 1'b0; bus_stb = 1'b0; bus_ack = 1'b0; bus_addr = 16'hFFFF;
    @(posedge clk); #1;
    if (bus_err) pulses++;
    @(posedge clk); #1;
    if (bus_err) pulses++;
    want = exp_err_edge(hold, ack_idx);
    check(req, "error edge", first_err, want);
    check("R5", "error pulse count", pulses, (want >= 0) ? 1 : 0);
    if (want >= 0) exp_fault = (stb2_idx <= want) ? a2 : a0;
    check((want >= 0) ? "R8" : "R7", "fault address", fault_addr, exp_fault);
  endtask

  initial begin
    rst_n = 1'b0; bus_cyc = 1'b0; bus_stb = 1'b0; bus_ack = 1'b0; bus_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", "error after reset", bus_err, 0);
    check("R1", "fault address after reset", fault_addr, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      int hold    = int'(VEC[v][31:24]);
      int ack_idx = int'(VEC[v][23:16]);
      int s2      = int'(VEC[v][15:8]);
      run_txn({8'hA0, VEC[v][7:0]}, hold, ack_idx, s2, {8'hB0, VEC[v][7:0]},
              (ack_idx == int'(LIMIT)) ? "R6" : "R4");
    end

    // R2: long idle with strobe, ack and address toggling
    begin
      int errs = 0;
      for (int i = 0; i < 4 * int'(LIMIT); i++) begin
        @(negedge clk);
        bus_stb = i[0]; bus_ack = i[1]; bus_addr = 16'h5000 | AW'(i);
        @(posedge clk); #1;
        if (bus_err) errs++;
      end
      @(negedge clk);
      bus_stb = 1'b0; bus_ack = 1'b0;
      check("R2", "errors while idle", errs, 0);
      check("R2", "fault address while idle", fault_addr, exp_fault);
    end

    // R3: a one-clock gap restarts the window
    begin
      int errs = 0;
      for (int seg = 0; seg < 2; seg++) begin
        for (int i = 0; i < int'(LIMIT); i++) begin
          @(negedge clk);
          bus_cyc = 1'b1; bus_stb = (i == 0); bus_addr = 16'h3300 | AW'(seg);
          @(posedge clk); #1;
          if (bus_err) errs++;
        end
        @(negedge clk);
        bus_cyc = 1'b0; bus_stb = 1'b0;
        @(posedge clk); #1;
        if (bus_err) errs++;
      end
      check("R3", "errors across one-clock gap", errs, 0);
      check("R3", "fault address across gap", fault_addr, exp_fault);
    end

    // R3 + R4: after the gap a genuinely hung cycle still faults
    run_txn(16'h4321, int'(LIMIT) + 1, 255, 255, 16'h0, "R3");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: bench hung, actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule